// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the bus-master state machine of one channel in a legacy-style DMA controller. It runs one data transfer at a time as a short sequence of bus states. It puts the channel address on the bus with the address-enable flag raised. It then raises the acknowledge toward the requesting device and drives the active-low read and write strobes for memory and I/O, cycle by cycle. Every completed transfer lowers a word counter by one. When that counter wraps past zero, the block pulses an active-low terminal-count output and stops.

The start address, a second (destination) address and the word count come from input pins. They are captured by a load pulse while the sequencer is idle. Four transfer styles are supported: single, block, demand, and a memory-to-memory loop that reads from the source address and writes to the destination address until the count runs out. Three options shape the strobe timing. A compatibility mode selects the legacy timing rules. An early-write option raises the write strobe one state sooner. A short-cycle option skips the wait state, so both pulses last one cycle. In the wait state the sequencer keeps looping while the wait input is high.

Top module: `dma_xfer_seq`

## Requirements
- R1: While idle (and after reset), aen and dack are 0, addrOut is 0, and memrN, memwN, iorN, iowN and eopOutN are all 1.
- R2: A transfer's first state raises aen and drives the captured source address with all strobes high. If dreq is low in that state, the sequencer returns to idle. Otherwise it continues.
- R3: In the second state dack rises and the read strobe falls. With ioToMem=0 the read strobe is memrN and the write strobe is iowN. With ioToMem=1 the read strobe is iorN and the write strobe is memwN.
- R4: The write strobe first falls in the second state when compatMode=0 or earlyWrite=1. Otherwise it first falls in the third state. Once low, it stays low through the fourth state. The read strobe is low in the second and third states only.
- R5: With compatMode=1 and shortCycle=1, the second state goes straight to the fourth. The read strobe is then low for exactly one cycle, and so is the write strobe when earlyWrite=0.
- R6: The third state repeats for as long as waitIn is sampled 1, with dack and the strobes held. It advances once waitIn is sampled 0.
- R7: The fourth state (and the last memory-to-memory state) lowers the count by one. If the count was 0 before the decrement, eopOutN is 0 for that single cycle. The sequencer then returns to idle and will not start again until a new load.
- R8: Single mode (xferMode=0) returns to idle after every transfer.
- R9: Block mode (xferMode=1) goes from the fourth state straight back to the first state without dreq. It stops after the current transfer if eopInN is sampled 0 in the second, third or fourth state.
- R10: Demand mode (xferMode=2) loops like block mode. It also stops after the current transfer if dreq is sampled 0 in the third or fourth state.
- R11: Memory-to-memory mode (xferMode=3) repeats four states. Two read states drive the source address with memrN low. A write state drives the destination address with memwN low. A final state keeps the destination address with memwN high. dack stays 0 throughout. The loop continues until terminal count, or until eopInN is sampled 0.
- R12: cfgLoad is taken only in idle, and then arms the channel. In idle, dreq starts a transfer only when the channel is armed and cfgLoad is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Capture addresses and count and arm the channel (idle only) |
| cfgSrcAddr | input | ADDR_W | Transfer address, and the source address in memory-to-memory mode |
| cfgDstAddr | input | ADDR_W | Destination address for memory-to-memory mode |
| cfgCount | input | CNT_W | Word count; value N gives N+1 transfers |
| xferMode | input | 2 | 0 single, 1 block, 2 demand, 3 memory-to-memory |
| ioToMem | input | 1 | 0: memory read / I/O write; 1: I/O read / memory write |
| compatMode | input | 1 | Legacy timing rules (early write, short cycle) enabled |
| earlyWrite | input | 1 | Write strobe starts in the second state |
| shortCycle | input | 1 | Skip the third state (legacy mode only) |
| dreq | input | 1 | Transfer request |
| waitIn | input | 1 | Holds the third state while 1 |
| eopInN | input | 1 | Active-low external end-of-transfer |
| aen | output | 1 | Address enable |
| addrOut | output | ADDR_W | Bus address, 0 when idle |
| dack | output | 1 | Transfer acknowledge |
| memrN | output | 1 | Active-low memory read strobe |
| memwN | output | 1 | Active-low memory write strobe |
| iorN | output | 1 | Active-low I/O read strobe |
| iowN | output | 1 | Active-low I/O write strobe |
| eopOutN | output | 1 | Active-low terminal-count pulse |

## Verification
The bench builds the block with ADDR_W=12 and CNT_W=8. The narrow counter means a full-range count of 255 wraps after 256 transfers, so the whole-counter rollover is reached in about a thousand cycles. The random phase loads small counts so that terminal count, aborts and demand drop-outs come up many times. The random inputs cover every mode and option mix. A reference model in the bench predicts every output on every cycle, and directed cases then measure the pulse widths, loop counts and stopping points.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_S1,
    ST_S2,
    ST_S3,
    ST_S4,
    ST_R1,
    ST_R2,
    ST_W1,
    ST_W2
  } seqState_t;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_BLOCK  = 2'd1,
    MODE_DEMAND = 2'd2,
    MODE_MEM    = 2'd3
  } xferMode_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadCfg;
    logic decCount;
    logic driveAddr;
    logic selDst;
  } dpCtl_t;

endpackage

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [CNT_W-1:0]  cfgCount,
  output logic [ADDR_W-1:0] addrOut,
  output logic              countZero,
  output logic              armed
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] srcAddr;
  logic [ADDR_W-1:0] dstAddr;
  logic [CNT_W-1:0]  wordCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr   <= '0;
      dstAddr   <= '0;
      wordCount <= '0;
      armed     <= 1'b0;
    end else if (dpCtl.loadCfg) begin
      srcAddr   <= cfgSrcAddr;
      dstAddr   <= cfgDstAddr;
      wordCount <= cfgCount;
      armed     <= 1'b1;
    end else if (dpCtl.decCount) begin
      wordCount <= wordCount - CNT_ONE;
      if (countZero) armed <= 1'b0;
    end
  end

  assign countZero = (wordCount == '0);

  always_comb begin
    if (!dpCtl.driveAddr)  addrOut = '0;
    else if (dpCtl.selDst) addrOut = dstAddr;
    else                   addrOut = srcAddr;
  end

  // R7: every decrement lowers the count by exactly one, wrapping at zero
  p_count_dec_r7: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.decCount |=> wordCount == $past(wordCount) - CNT_ONE);

  // R7: a decrement taken at zero disarms the channel
  p_term_disarm_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.decCount && countZero && !dpCtl.loadCfg) |=> !armed);

  // R12: a load arms the channel
  p_load_arm_r12: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.loadCfg |=> armed);

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgLoad,
  input  logic [1:0] xferMode,
  input  logic       ioToMem,
  input  logic       compatMode,
  input  logic       earlyWrite,
  input  logic       shortCycle,
  input  logic       dreq,
  input  logic       waitIn,
  input  logic       eopInN,
  input  logic       countZero,
  input  logic       armed,
  output dpCtl_t     dpCtl,
  output logic       aen,
  output logic       dack,
  output logic       memrN,
  output logic       memwN,
  output logic       iorN,
  output logic       iowN,
  output logic       eopOutN
);

  seqState_t state, nextState;
  xferMode_t mode;
  logic      abortSeen;
  logic      dreqLost;
  logic      inIoXfer;
  logic      inMemXfer;
  logic      ioStop;
  logic      memStop;
  logic      readPhase;
  logic      writePhase;
  logic      lastState;

  assign mode      = xferMode_t'(xferMode);
  assign inIoXfer  = (state == ST_S2) || (state == ST_S3) || (state == ST_S4);
  assign inMemXfer = (state == ST_R1) || (state == ST_R2) ||
                     (state == ST_W1) || (state == ST_W2);
  assign lastState = (state == ST_S4) || (state == ST_W2);

  assign ioStop  = abortSeen || !eopInN || (mode == MODE_SINGLE) ||
                   ((mode == MODE_DEMAND) && (dreqLost || !dreq));
  assign memStop = abortSeen || !eopInN;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (!cfgLoad && armed && dreq)
          nextState = (mode == MODE_MEM) ? ST_R1 : ST_S1;
      end
      ST_S1:   nextState = dreq ? ST_S2 : ST_IDLE;
      ST_S2:   nextState = (compatMode && shortCycle) ? ST_S4 : ST_S3;
      ST_S3:   nextState = waitIn ? ST_S3 : ST_S4;
      ST_S4:   nextState = (countZero || ioStop) ? ST_IDLE : ST_S1;
      ST_R1:   nextState = ST_R2;
      ST_R2:   nextState = ST_W1;
      ST_W1:   nextState = ST_W2;
      ST_W2:   nextState = (countZero || memStop) ? ST_IDLE : ST_R1;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      abortSeen <= 1'b0;
      dreqLost  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE) begin
        abortSeen <= 1'b0;
        dreqLost  <= 1'b0;
      end else begin
        if ((inIoXfer || inMemXfer) && !eopInN) abortSeen <= 1'b1;
        if ((state == ST_S3) && !dreq)          dreqLost  <= 1'b1;
      end
    end
  end

  // strobe placement per state
  assign readPhase  = (state == ST_S2) || (state == ST_S3);
  assign writePhase = (state == ST_S3) || (state == ST_S4) ||
                      ((state == ST_S2) && (!compatMode || earlyWrite));

  always_comb begin
    aen     = (state != ST_IDLE);
    dack    = inIoXfer;
    memrN   = !((readPhase && !ioToMem) || (state == ST_R1) || (state == ST_R2));
    iorN    = !(readPhase && ioToMem);
    iowN    = !(writePhase && !ioToMem);
    memwN   = !((writePhase && ioToMem) || (state == ST_W1));
    eopOutN = !(lastState && countZero);
  end

  always_comb begin
    dpCtl.loadCfg   = (state == ST_IDLE) && cfgLoad;
    dpCtl.decCount  = lastState;
    dpCtl.driveAddr = (state != ST_IDLE);
    dpCtl.selDst    = (state == ST_W1) || (state == ST_W2);
  end

  // R2: dropped request in the address state returns to idle
  p_s1_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S1 && !dreq) |=> state == ST_IDLE);

  // R3: acknowledge only with the address enabled
  p_dack_aen_r3: assert property (@(posedge clk) disable iff (!rstN)
    dack |-> aen);

  // R5: short cycle skips the wait state
  p_short_skip_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S2 && compatMode && shortCycle) |=> state == ST_S4);

  // R6: wait input holds the third state and its strobes
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S3 && waitIn) |=> (state == ST_S3 && dack && $stable(memrN) && $stable(iorN)));

  // R7: terminal pulse is followed by idle
  p_eop_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    !eopOutN |=> state == ST_IDLE);

  // R8: single mode never chains transfers
  p_single_ret_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S4 && mode == MODE_SINGLE) |=> state == ST_IDLE);

  // R9: a sampled external end stops after the current transfer
  p_abort_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S4 && abortSeen) |=> state == ST_IDLE);

  // R11: the memory loop never acknowledges a device
  p_mem_nodack_r11: assert property (@(posedge clk) disable iff (!rstN)
    inMemXfer |-> !dack);

  // R1: at most one strobe of each direction at a time
  p_strobe_pair_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones({!memrN, !iorN}) <= 1 && $countones({!memwN, !iowN}) <= 1);

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [1:0]        xferMode,
  input  logic              ioToMem,
  input  logic              compatMode,
  input  logic              earlyWrite,
  input  logic              shortCycle,
  input  logic              dreq,
  input  logic              waitIn,
  input  logic              eopInN,
  output logic              aen,
  output logic [ADDR_W-1:0] addrOut,
  output logic              dack,
  output logic              memrN,
  output logic              memwN,
  output logic              iorN,
  output logic              iowN,
  output logic              eopOutN
);

  dpCtl_t dpCtl;
  logic   countZero;
  logic   armed;

  dma_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgLoad    (cfgLoad),
    .xferMode   (xferMode),
    .ioToMem    (ioToMem),
    .compatMode (compatMode),
    .earlyWrite (earlyWrite),
    .shortCycle (shortCycle),
    .dreq       (dreq),
    .waitIn     (waitIn),
    .eopInN     (eopInN),
    .countZero  (countZero),
    .armed      (armed),
    .dpCtl      (dpCtl),
    .aen        (aen),
    .dack       (dack),
    .memrN      (memrN),
    .memwN      (memwN),
    .iorN       (iorN),
    .iowN       (iowN),
    .eopOutN    (eopOutN)
  );

  dma_seq_dp #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtl      (dpCtl),
    .cfgSrcAddr (cfgSrcAddr),
    .cfgDstAddr (cfgDstAddr),
    .cfgCount   (cfgCount),
    .addrOut    (addrOut),
    .countZero  (countZero),
    .armed      (armed)
  );

endmodule

// File: tb/dma_xfer_seq_test.sv
module dma_xfer_seq_test;

  localparam int AW = 12;
  localparam int CW = 8;

  // bench model states
  localparam int M_IDLE = 0, M_S1 = 1, M_S2 = 2, M_S3 = 3, M_S4 = 4,
                 M_R1 = 5, M_R2 = 6, M_W1 = 7, M_W2 = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgLoad = 1'b0;
  logic [AW-1:0] cfgSrcAddr = '0;
  logic [AW-1:0] cfgDstAddr = '0;
  logic [CW-1:0] cfgCount = '0;
  logic [1:0]    xferMode = 2'd0;
  logic          ioToMem = 1'b0;
  logic          compatMode = 1'b0;
  logic          earlyWrite = 1'b0;
  logic          shortCycle = 1'b0;
  logic          dreq = 1'b0;
  logic          waitIn = 1'b0;
  logic          eopInN = 1'b1;
  logic          aen, dack, memrN, memwN, iorN, iowN, eopOutN;
  logic [AW-1:0] addrOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // model state
  int            mSt = M_IDLE;
  logic [CW-1:0] mCnt = '0;
  bit            mArmed = 0, mAbort = 0, mDrop = 0;
  logic [AW-1:0] mSrc = '0, mDst = '0;

  // pulse counters
  int dackRise = 0, eopLow = 0, memrLow = 0, iowLow = 0, memwLow = 0;
  logic prevDack = 1'b0;

  always #4 clk = ~clk;

  dma_xfer_seq #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgSrcAddr(cfgSrcAddr),
    .cfgDstAddr(cfgDstAddr), .cfgCount(cfgCount), .xferMode(xferMode),
    .ioToMem(ioToMem), .compatMode(compatMode), .earlyWrite(earlyWrite),
    .shortCycle(shortCycle), .dreq(dreq), .waitIn(waitIn), .eopInN(eopInN),
    .aen(aen), .addrOut(addrOut), .dack(dack), .memrN(memrN), .memwN(memwN),
    .iorN(iorN), .iowN(iowN), .eopOutN(eopOutN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input int st);
    case (st)
      M_IDLE: return "R1 idle outputs";
      M_S1:   return "R2 address state";
      M_S2:   return "R3/R4 second state";
      M_S3:   return "R4/R6 third state";
      M_S4:   return "R7 fourth state";
      default: return "R11 memory loop";
    endcase
  endfunction

  // expected {aen,dack,memrN,memwN,iorN,iowN,eopOutN,addr}
  function automatic logic [AW+6:0] expOut(input int st);
    bit rd, wr, isAen, isDack;
    logic [AW-1:0] a;
    rd = (st == M_S2) || (st == M_S3);
    wr = (st == M_S3) || (st == M_S4) || ((st == M_S2) && (!compatMode || earlyWrite));
    isAen = (st != M_IDLE);
    isDack = (st == M_S2) || (st == M_S3) || (st == M_S4);
    a = (st == M_IDLE) ? '0 : ((st == M_W1 || st == M_W2) ? mDst : mSrc);
    return {isAen, isDack,
            !((rd && !ioToMem) || st == M_R1 || st == M_R2),
            !((wr && ioToMem) || st == M_W1),
            !(rd && ioToMem),
            !(wr && !ioToMem),
            !((st == M_S4 || st == M_W2) && mCnt == '0),
            a};
  endfunction

  // reference model step
  always @(posedge clk) begin
    if (!rstN) begin
      mSt = M_IDLE; mCnt = '0; mArmed = 0; mAbort = 0; mDrop = 0; mSrc = '0; mDst = '0;
    end else begin
      int nx;
      bit term, stop;
      nx = mSt;
      if (mSt != M_IDLE && mSt != M_S1 && !eopInN) mAbort = 1;
      case (mSt)
        M_IDLE: begin
          if (cfgLoad) begin
            mSrc = cfgSrcAddr; mDst = cfgDstAddr; mCnt = cfgCount; mArmed = 1;
          end else if (mArmed && dreq) nx = (xferMode == 2'd3) ? M_R1 : M_S1;
          mAbort = 0; mDrop = 0;
        end
        M_S1: nx = dreq ? M_S2 : M_IDLE;
        M_S2: nx = (compatMode && shortCycle) ? M_S4 : M_S3;
        M_S3: begin
          if (!dreq) mDrop = 1;
          nx = waitIn ? M_S3 : M_S4;
        end
        M_S4: begin
          stop = mAbort || (xferMode == 2'd0) ||
                 (xferMode == 2'd2 && (mDrop || !dreq));
          term = (mCnt == '0);
          if (term) mArmed = 0;
          mCnt = mCnt - 1'b1;
          nx = (term || stop) ? M_IDLE : M_S1;
        end
        M_R1: nx = M_R2;
        M_R2: nx = M_W1;
        M_W1: nx = M_W2;
        M_W2: begin
          term = (mCnt == '0);
          if (term) mArmed = 0;
          mCnt = mCnt - 1'b1;
          nx = (term || mAbort) ? M_IDLE : M_R1;
        end
        default: nx = M_IDLE;
      endcase
      mSt = nx;
    end
  end

  // per-cycle comparison and pulse counting, away from the clock edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [AW+6:0] act, exp;
      act = {aen, dack, memrN, memwN, iorN, iowN, eopOutN, addrOut};
      exp = expOut(mSt);
      check(act === exp, tagOf(mSt), int'(act), int'(exp));
      if (dack && !prevDack) dackRise++;
      if (!eopOutN) eopLow++;
      if (!memrN) memrLow++;
      if (!iowN) iowLow++;
      if (!memwN) memwLow++;
      prevDack = dack;
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic clearCounts();
    dackRise = 0; eopLow = 0; memrLow = 0; iowLow = 0; memwLow = 0;
  endtask

  task automatic loadCfg(input logic [CW-1:0] cnt);
    cfgSrcAddr = AW'($urandom);
    cfgDstAddr = AW'($urandom);
    cfgCount = cnt;
    cfgLoad = 1'b1;
    cyc(1);
    cfgLoad = 1'b0;
  endtask

  task automatic setOpts(input logic [1:0] md, input bit dir, input bit cm,
                         input bit ew, input bit sc);
    xferMode = md; ioToMem = dir; compatMode = cm; earlyWrite = ew; shortCycle = sc;
  endtask

  initial begin
    void'($urandom(32'h5eed_0c1a));
    cyc(3);
    // R1: reset state
    check({aen, dack, memrN, memwN, iorN, iowN, eopOutN} == 7'b0011111 && addrOut == '0,
          "R1 reset outputs", int'({aen, dack, memrN, memwN, iorN, iowN, eopOutN}), 'h1f);
    rstN = 1'b1;
    cyc(2);

    // R12: unarmed channel ignores dreq
    dreq = 1'b1; cyc(4);
    check(aen == 1'b0, "R12 unarmed start", int'(aen), 0);
    dreq = 1'b0; cyc(1);

    // R7/R9: full-range rollover in block mode
    setOpts(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    loadCfg(8'hFF);
    clearCounts();
    dreq = 1'b1;
    cyc(1100);
    check(dackRise == 256, "R9 block transfers to rollover", dackRise, 256);
    check(eopLow == 1, "R7 terminal pulse count", eopLow, 1);
    check(aen == 1'b0, "R7 no restart after terminal", int'(aen), 0);
    dreq = 1'b0; cyc(1);

    // R5: short cycle, single mode
    setOpts(2'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    loadCfg(8'd3);
    clearCounts();
    dreq = 1'b1; cyc(3); dreq = 1'b0; cyc(5);
    check(memrLow == 1, "R5 read width short cycle", memrLow, 1);
    check(iowLow == 1, "R5 write width short cycle", iowLow, 1);
    check(dackRise == 1, "R8 single transfer", dackRise, 1);

    // R4: legacy without early write: write covers third and fourth states
    setOpts(2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    clearCounts();
    dreq = 1'b1; cyc(3); dreq = 1'b0; cyc(5);
    check(memrLow == 2 && iowLow == 2, "R4 late write width", iowLow, 2);
    setOpts(2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    clearCounts();
    dreq = 1'b1; cyc(3); dreq = 1'b0; cyc(5);
    check(iowLow == 3, "R4 early write width", iowLow, 3);

    // R6: wait loop
    setOpts(2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    waitIn = 1'b1;
    dreq = 1'b1; cyc(3); dreq = 1'b0; cyc(10);
    check(dack && !iorN && !memwN, "R6 held in wait state",
          int'({dack, iorN, memwN}), 'b100);
    waitIn = 1'b0; cyc(4);
    check(aen == 1'b0, "R6 leaves wait state", int'(aen), 0);

    // R9: external end stops block mode after one transfer
    setOpts(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    loadCfg(8'd10);
    clearCounts();
    eopInN = 1'b0;
    dreq = 1'b1; cyc(3); dreq = 1'b0; cyc(10);
    eopInN = 1'b1;
    check(dackRise == 1, "R9 abort after one transfer", dackRise, 1);
    check(eopLow == 0, "R9 no terminal on abort", eopLow, 0);

    // R10: demand mode stops when dreq drops
    setOpts(2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    loadCfg(8'd10);
    clearCounts();
    dreq = 1'b1; cyc(6); dreq = 1'b0; cyc(8);
    check(dackRise == 2, "R10 demand drop", dackRise, 2);
    check(aen == 1'b0, "R10 idle after drop", int'(aen), 0);

    // R11: memory-to-memory loop, count 2 gives three writes
    setOpts(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    loadCfg(8'd2);
    clearCounts();
    dreq = 1'b1; cyc(2); dreq = 1'b0; cyc(16);
    check(memwLow == 3, "R11 memory writes", memwLow, 3);
    check(memrLow == 6, "R11 memory reads", memrLow, 6);
    check(eopLow == 1 && dackRise == 0, "R11 terminal without dack", eopLow, 1);

    // random phase, every cycle checked against the model
    for (int i = 0; i < 8000; i++) begin
      if (mSt == M_IDLE) begin
        xferMode   = 2'($urandom_range(0, 3));
        ioToMem    = 1'($urandom);
        compatMode = 1'($urandom);
        earlyWrite = 1'($urandom);
        shortCycle = 1'($urandom);
        cfgLoad    = ($urandom_range(0, 7) == 0);
        cfgSrcAddr = AW'($urandom);
        cfgDstAddr = AW'($urandom);
        cfgCount   = ($urandom_range(0, 15) == 0) ? CW'($urandom) : CW'($urandom_range(0, 5));
      end else begin
        cfgLoad    = ($urandom_range(0, 7) == 0);
      end
      dreq   = ($urandom_range(0, 3) != 0);
      waitIn = ($urandom_range(0, 2) == 0);
      eopInN = ($urandom_range(0, 15) != 0);
      cyc(1);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule